// File: doc/BRIEF.md
# Addressed Three-Wire Configuration Port

This block takes synthesizer control words from a slow three-wire serial bus and turns them into the parallel settings that a divider chain and a fractional modulator consume. The bus has a data line and a shift clock, and a load strobe commits a word. All bus lines are asynchronous to the block. They are brought into the system clock domain, and their edges are found by comparing samples. No bus line is ever used as a clock.

A 21-bit word is shifted in with the first bit at the top. Its last bit is an address bit, and it selects one of two destinations when the load strobe rises. Address 0 writes the divider settings: the reference divide value, the main divide value, the swallow count and the prescaler bypass flag. Address 1 writes the 18-bit fractional word.

A second strobe, when high, sends the shifted bits into a separate 8-bit mode word instead. That word reaches its holding copy only when the strobe falls. Its active bits are released to the outputs only while an active-low mode input is held low. A direct-mode input takes the divider and fractional values from parallel pins in place of the serial registers.

Top module: `cfg3w_port`

## Requirements
- R1: After reset every output is zero: all divide values, the fractional word, the bypass flag, the mode bits, and test select 0.
- R2: With both strobes low, each rising edge of the shift clock shifts the data line into a 21-bit primary word, first bit at the top. On a rising edge of the load strobe, a word whose last bit is 0 updates the divider outputs. The order in which the 20 payload bits arrive is R[5], R[4], M[8], M[7], bypass, M[6]..M[0], R[3]..R[0], A[3]..A[0].
- R3: On a rising edge of the load strobe, a word whose last bit is 1 updates the fractional output. Its 18 bits arrive first, most significant first, and are followed by two ignored bits. The divider outputs are left unchanged.
- R4: When more than 21 bits are shifted before a load, only the last 21 bits shifted take effect.
- R5: Shift-clock edges while the mode strobe is high do not change the primary word. A later load therefore commits the word that was shifted before.
- R6: While the mode strobe is high, its shifted bits arrive in bit order 0 first. The mode outputs change only when the mode strobe falls, and never before.
- R7: While the active-low mode input is high, the power-down, forced-load and lock-detect-disable outputs are 0 and test select is 0. The held mode bits are kept, and they return when the mode input goes low.
- R8: The mode bits are: 0 and 1 ignored, 2 feedback divider to test pin, 3 power down, 4 forced continuous load, 5 modulus select to test pin, 6 reference divider to test pin, 7 lock detect disable. Test select is 1 if bit 2 is set, otherwise 2 if bit 5 is set, otherwise 3 if bit 6 is set, otherwise 0.
- R9: While the direct input is high, the divider, bypass and fractional outputs equal the parallel pins. When it goes low, the outputs return to the serially loaded values.
- R10: Shifting a complete word without a load strobe leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| sdata_i | input | 1 | serial data line |
| sclk_i | input | 1 | serial shift clock, sampled |
| load_i | input | 1 | load strobe, commits on rising edge |
| enh_i | input | 1 | mode-word strobe, high routes shifting to the mode word |
| enh_n_i | input | 1 | active-low enable for the mode bits |
| direct_i | input | 1 | high selects the parallel pins |
| par_r_i | input | 6 | parallel reference divide value |
| par_m_i | input | 9 | parallel main divide value |
| par_a_i | input | 4 | parallel swallow count |
| par_byp_i | input | 1 | parallel prescaler bypass |
| par_k_i | input | 18 | parallel fractional word |
| r_o | output | 6 | reference divide value |
| m_o | output | 9 | main divide value |
| a_o | output | 4 | swallow count |
| bypass_o | output | 1 | prescaler bypass |
| k_o | output | 18 | fractional word |
| pwr_dn_o | output | 1 | power down request |
| force_load_o | output | 1 | forced continuous counter load |
| ld_off_o | output | 1 | lock detect disable |
| tsel_o | output | 2 | test pin source: 0 none, 1 feedback, 2 modulus select, 3 reference |

## Verification
The hardest cases to reach are those where an earlier bus phase could silently corrupt later state. One is a mode-word transfer that leaks into the primary word. The other is a mode word seen before its strobe falls. To expose a leak, the bench ends the mode word with a 1 in bit 7 and then pulses the load strobe with no new shifting. A primary word corrupted by the mode bits would then carry address 1 and a changed payload, so a wrong destination or wrong values would show. The mode outputs are compared while the mode strobe is still high, and again after it falls. The bench also shifts a word without loading it, and shifts a word with four leading junk bits, so that both checks work through the outputs alone.

// File: rtl/cfg3w_pkg.sv
package cfg3w_pkg;
   localparam int R_W      = 6;
   localparam int M_W      = 9;
   localparam int A_W      = 4;
   localparam int K_W      = 18;
   localparam int WORD_W   = 21;
   localparam int PAY_W    = WORD_W - 1;
   localparam int ENH_W    = 8;
   localparam int ENH_RSV  = 2;
   localparam int ENH_KEEP = ENH_W - ENH_RSV;

   typedef struct packed {
      logic [R_W-1:0] r;
      logic [M_W-1:0] m;
      logic [A_W-1:0] a;
      logic           byp;
   } div_t;

   // bit order follows shift order: first kept bit on top
   typedef struct packed {
      logic fb_tst;
      logic pwr_dn;
      logic cnt_ld;
      logic msel_tst;
      logic ref_tst;
      logic ld_dis;
   } enh_t;

   typedef enum logic [1:0] {
      TS_NONE = 2'd0,
      TS_FB   = 2'd1,
      TS_MSEL = 2'd2,
      TS_REF  = 2'd3
   } tsel_e;

   function automatic div_t unpack_div(input logic [PAY_W-1:0] p);
      div_t d;
      d.r   = {p[19:18], p[7:4]};
      d.m   = {p[17:16], p[14:8]};
      d.byp = p[15];
      d.a   = p[3:0];
      return d;
   endfunction

   function automatic tsel_e pick_tsel(input enh_t e);
      if (e.fb_tst)        return TS_FB;
      else if (e.msel_tst) return TS_MSEL;
      else if (e.ref_tst)  return TS_REF;
      else                 return TS_NONE;
   endfunction
endpackage

// File: rtl/cfg3w_sync.sv
module cfg3w_sync #(
   parameter int N      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] sync_o
);
   generate
      if (STAGES < 0 || STAGES > 4) begin : g_bad
         $error("cfg3w_sync: STAGES must be 0..4");
      end
      if (STAGES == 0) begin : g_pass
         assign sync_o = async_i;
      end else begin : g_chain
         for (genvar b = 0; b < N; b++) begin : g_bit
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q <= '0;
               else if (STAGES == 1) chain_q <= async_i[b];
               else chain_q <= {chain_q[STAGES-2:0], async_i[b]};
            end
            assign sync_o[b] = chain_q[STAGES-1];
         end
      end
   endgenerate
endmodule

// File: rtl/cfg3w_shreg.sv
module cfg3w_shreg #(
   parameter int W = 21
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         shift_i,
   input  logic         din_i,
   output logic [W-1:0] q_o
);
   generate
      if (W < 2) begin : g_bad
         $error("cfg3w_shreg: W must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o <= '0;
      else if (shift_i) q_o <= {q_o[W-2:0], din_i};
   end
endmodule

// File: rtl/cfg3w_port.sv
module cfg3w_port
   import cfg3w_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic           sdata_i,
   input  logic           sclk_i,
   input  logic           load_i,
   input  logic           enh_i,
   input  logic           enh_n_i,
   input  logic           direct_i,
   input  logic [R_W-1:0] par_r_i,
   input  logic [M_W-1:0] par_m_i,
   input  logic [A_W-1:0] par_a_i,
   input  logic           par_byp_i,
   input  logic [K_W-1:0] par_k_i,
   output logic [R_W-1:0] r_o,
   output logic [M_W-1:0] m_o,
   output logic [A_W-1:0] a_o,
   output logic           bypass_o,
   output logic [K_W-1:0] k_o,
   output logic           pwr_dn_o,
   output logic           force_load_o,
   output logic           ld_off_o,
   output logic [1:0]     tsel_o
);
   localparam int NSYNC = 4;

   generate
      if (R_W + M_W + A_W + 1 != PAY_W) begin : g_chk_div
         $error("cfg3w_port: divider fields do not fill the payload");
      end
      if (K_W + 2 != PAY_W) begin : g_chk_k
         $error("cfg3w_port: fractional field does not fit the payload");
      end
      if ($bits(enh_t) != ENH_KEEP) begin : g_chk_e
         $error("cfg3w_port: mode word size mismatch");
      end
   endgenerate

   logic [NSYNC-1:0] sync_w;
   logic             sd_s, sck_s, ld_s, en_s;
   logic             sck_prev_q, ld_prev_q, en_prev_q;
   logic             sclk_rise, load_rise, enh_fall;

   cfg3w_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i ({enh_i, load_i, sclk_i, sdata_i}),
      .sync_o  (sync_w)
   );

   assign {en_s, ld_s, sck_s, sd_s} = sync_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sck_prev_q <= 1'b0;
         ld_prev_q  <= 1'b0;
         en_prev_q  <= 1'b0;
      end else begin
         sck_prev_q <= sck_s;
         ld_prev_q  <= ld_s;
         en_prev_q  <= en_s;
      end
   end

   assign sclk_rise = sck_s & ~sck_prev_q;
   assign load_rise = ld_s & ~ld_prev_q;
   assign enh_fall  = ~en_s & en_prev_q;

   logic                prim_shift, enh_shift;
   logic [WORD_W-1:0]   prim_q;
   logic [ENH_KEEP-1:0] eshift_q;

   assign prim_shift = sclk_rise & ~en_s & ~ld_s;
   assign enh_shift  = sclk_rise & en_s & ~ld_s;

   cfg3w_shreg #(.W(WORD_W)) u_prim (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (prim_shift),
      .din_i   (sd_s),
      .q_o     (prim_q)
   );

   // reserved leading bits fall off the top of this shorter register
   cfg3w_shreg #(.W(ENH_KEEP)) u_enh (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .shift_i (enh_shift),
      .din_i   (sd_s),
      .q_o     (eshift_q)
   );

   logic [PAY_W-1:0] cnt_reg;
   logic [K_W-1:0]   frac_reg;
   enh_t             enh_hold;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_reg  <= '0;
         frac_reg <= '0;
      end else if (load_rise) begin
         if (prim_q[0]) frac_reg <= prim_q[WORD_W-1 -: K_W];
         else           cnt_reg  <= prim_q[WORD_W-1:1];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       enh_hold <= '0;
      else if (enh_fall) enh_hold <= enh_t'(eshift_q);
   end

   div_t ser_div;
   enh_t enh_eff;

   assign ser_div = unpack_div(cnt_reg);

   always_comb begin
      if (direct_i) begin
         r_o      = par_r_i;
         m_o      = par_m_i;
         a_o      = par_a_i;
         bypass_o = par_byp_i;
         k_o      = par_k_i;
      end else begin
         r_o      = ser_div.r;
         m_o      = ser_div.m;
         a_o      = ser_div.a;
         bypass_o = ser_div.byp;
         k_o      = frac_reg;
      end
   end

   assign enh_eff      = enh_n_i ? '0 : enh_hold;
   assign pwr_dn_o     = enh_eff.pwr_dn;
   assign force_load_o = enh_eff.cnt_ld;
   assign ld_off_o     = enh_eff.ld_dis;
   assign tsel_o       = pick_tsel(enh_eff);
endmodule

// File: rtl/cfg3w_port_chk.sv
module cfg3w_port_chk
   import cfg3w_pkg::*;
(
   input logic             clk_i,
   input logic             rst_ni,
   input logic             load_rise,
   input logic             enh_fall,
   input logic             prim_lsb,
   input logic [PAY_W-1:0] cnt_reg,
   input logic [K_W-1:0]   frac_reg,
   input logic [ENH_KEEP-1:0] enh_hold,
   input logic             enh_n_i,
   input logic             direct_i,
   input logic [M_W-1:0]   par_m_i,
   input logic [K_W-1:0]   par_k_i,
   input logic [M_W-1:0]   m_o,
   input logic [K_W-1:0]   k_o,
   input logic             pwr_dn_o,
   input logic             force_load_o,
   input logic             ld_off_o,
   input logic [1:0]       tsel_o
);
   a_r10_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !load_rise |=> $stable(cnt_reg));

   a_r3_cnt_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_rise && prim_lsb) |=> $stable(cnt_reg));

   a_r2_frac_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (load_rise && !prim_lsb) |=> $stable(frac_reg));

   a_r6_hold_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !enh_fall |=> $stable(enh_hold));

   a_r7_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      enh_n_i |-> (!pwr_dn_o && !force_load_o && !ld_off_o && tsel_o == 2'd0));

   a_r9_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
      direct_i |-> (m_o == par_m_i && k_o == par_k_i));
endmodule

bind cfg3w_port cfg3w_port_chk chk_i (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .load_rise    (load_rise),
   .enh_fall     (enh_fall),
   .prim_lsb     (prim_q[0]),
   .cnt_reg      (cnt_reg),
   .frac_reg     (frac_reg),
   .enh_hold     (enh_hold),
   .enh_n_i      (enh_n_i),
   .direct_i     (direct_i),
   .par_m_i      (par_m_i),
   .par_k_i      (par_k_i),
   .m_o          (m_o),
   .k_o          (k_o),
   .pwr_dn_o     (pwr_dn_o),
   .force_load_o (force_load_o),
   .ld_off_o     (ld_off_o),
   .tsel_o       (tsel_o)
);

// File: tb/cfg3w_port_tb.sv
`timescale 1ns/1ps
module cfg3w_port_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic sd = 0, sck = 0, ld = 0, en = 0, en_n = 0, dir = 0;
   logic [5:0]  pr = 0;
   logic [8:0]  pm = 0;
   logic [3:0]  pa = 0;
   logic        pb = 0;
   logic [17:0] pk = 0;
   logic [5:0]  r_o;
   logic [8:0]  m_o;
   logic [3:0]  a_o;
   logic        byp_o, pd_o, fl_o, ldo_o;
   logic [17:0] k_o;
   logic [1:0]  ts_o;

   cfg3w_port dut_i (
      .clk_i(clk), .rst_ni(rst_n), .sdata_i(sd), .sclk_i(sck), .load_i(ld),
      .enh_i(en), .enh_n_i(en_n), .direct_i(dir), .par_r_i(pr), .par_m_i(pm),
      .par_a_i(pa), .par_byp_i(pb), .par_k_i(pk), .r_o(r_o), .m_o(m_o),
      .a_o(a_o), .bypass_o(byp_o), .k_o(k_o), .pwr_dn_o(pd_o),
      .force_load_o(fl_o), .ld_off_o(ldo_o), .tsel_o(ts_o)
   );

   typedef struct packed {
      logic [8:0]  m;
      logic [5:0]  r;
      logic [3:0]  a;
      logic        b;
      logic [17:0] k;
      logic        pd, fl, lo;
      logic [1:0]  ts;
   } snap_t;

   snap_t exp_q[$];
   string tag_q[$];
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   // bench model
   logic [5:0] mr = 0; logic [8:0] mm = 0; logic [3:0] ma = 0; logic mb = 0;
   logic [17:0] mk = 0; logic [7:0] me = 0;

   function automatic snap_t expect_now();
      snap_t s;
      s.m = dir ? pm : mm; s.r = dir ? pr : mr; s.a = dir ? pa : ma;
      s.b = dir ? pb : mb; s.k = dir ? pk : mk;
      s.pd = !en_n && me[3]; s.fl = !en_n && me[4]; s.lo = !en_n && me[7];
      if (en_n)       s.ts = 2'd0;
      else if (me[2]) s.ts = 2'd1;
      else if (me[5]) s.ts = 2'd2;
      else if (me[6]) s.ts = 2'd3;
      else            s.ts = 2'd0;
      return s;
   endfunction

   function automatic logic [20:0] mk_cnt(logic [5:0] r, logic [8:0] m, logic [3:0] a, logic b);
      return {r[5:4], m[8:7], b, m[6:0], r[3:0], a, 1'b0};
   endfunction

   function automatic logic [20:0] mk_frac(logic [17:0] k);
      return {k, 2'b00, 1'b1};
   endfunction

   task automatic tk(int n); repeat (n) @(negedge clk); endtask

   task automatic sbit(logic b);
      sd = b; tk(4); sck = 1; tk(4); sck = 0;
   endtask

   task automatic shift_word(logic [20:0] w);
      for (int i = 20; i >= 0; i--) sbit(w[i]);
      tk(4);
   endtask

   task automatic pulse_load();
      ld = 1; tk(6); ld = 0; tk(6);
   endtask

   task automatic push(string tag);
      exp_q.push_back(expect_now());
      tag_q.push_back(tag);
      while (exp_q.size() != 0) @(posedge clk);
   endtask

   // monitor: compares each expected snapshot once outputs have settled
   initial begin
      snap_t act, e;
      forever begin
         while (exp_q.size() == 0) @(posedge clk);
         repeat (12) @(posedge clk);
         @(negedge clk);
         act = {m_o, r_o, a_o, byp_o, k_o, pd_o, fl_o, ldo_o, ts_o};
         e = exp_q[0];
         n_cmp++;
         if (act !== e) begin
            n_bad++;
            $display("FAIL %s: actual m=%h r=%h a=%h b=%b k=%h pd=%b fl=%b lo=%b ts=%0d expected m=%h r=%h a=%h b=%b k=%h pd=%b fl=%b lo=%b ts=%0d",
               tag_q[0], act.m, act.r, act.a, act.b, act.k, act.pd, act.fl, act.lo, act.ts,
               e.m, e.r, e.a, e.b, e.k, e.pd, e.fl, e.lo, e.ts);
         end
         void'(exp_q.pop_front());
         void'(tag_q.pop_front());
      end
   end

   task automatic send_enh(logic [7:0] v, string tag_pre);
      en = 1; tk(6);
      for (int i = 0; i < 8; i++) sbit(v[i]);
      tk(6);
      push(tag_pre);          // R6: not yet visible
      en = 0; tk(6);
      me = v;
   endtask

   initial begin
      tk(3); rst_n = 1; tk(3);
      push("R1 reset state");

      shift_word(mk_cnt(6'h2D, 9'h1A5, 4'd9, 1'b0)); pulse_load();
      mr = 6'h2D; mm = 9'h1A5; ma = 4'd9; mb = 0;
      push("R2 divider word");

      shift_word(mk_cnt(6'h12, 9'h05A, 4'd3, 1'b1)); pulse_load();
      mr = 6'h12; mm = 9'h05A; ma = 4'd3; mb = 1;
      push("R2 divider word with bypass");

      shift_word(mk_frac(18'h2B3C5)); pulse_load();
      mk = 18'h2B3C5;
      push("R3 fractional word, divider kept");

      shift_word(mk_cnt(6'h3F, 9'h1FF, 4'hF, 1'b0));
      push("R10 shifted without load");
      pulse_load();
      mr = 6'h3F; mm = 9'h1FF; ma = 4'hF; mb = 0;
      push("R2 all-ones divider after load");

      for (int i = 0; i < 4; i++) sbit(1'b1);
      shift_word(mk_cnt(6'h01, 9'h100, 4'd5, 1'b1)); pulse_load();
      mr = 6'h01; mm = 9'h100; ma = 4'd5; mb = 1;
      push("R4 overlength keeps last 21");

      send_enh(8'b1000_1100, "R6 mode word before strobe fall");
      push("R8 mode bits 2,3,7 after fall");

      pulse_load();
      push("R5 primary untouched by mode shifting");

      en_n = 1; tk(2);
      push("R7 mode bits gated");
      en_n = 0; tk(2);
      push("R7 mode bits return");

      send_enh(8'b0110_0000, "R6 second mode word before fall");
      push("R8 bits 5,6 select modulus");
      send_enh(8'b0101_0011, "R6 third mode word before fall");
      push("R8 bit 6 select reference, bit 4 force load, reserved ignored");

      pr = 6'h2A; pm = 9'h0C3; pa = 4'd7; pb = 1; pk = 18'h15A5A; dir = 1; tk(2);
      push("R9 direct pins drive outputs");
      dir = 0; tk(2);
      push("R9 serial values return");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule